// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Controller

This block produces a family of related clocks from one fast reference clock and lets power management halt two of the groups without runts. A phase counter divides the reference clock. A CPU group runs at one half of the reference rate. A free-running PCI_F clock runs at one eighth of the reference rate. A group of gated PCI clocks has the same frequency and phase as PCI_F. Every output comes straight from a flop that the reference clock drives.

Each group has an active-low stop input, and the stop inputs may arrive asynchronously. Each one passes through a two-flop synchronizer. A group's enable changes only on the reference edge where PCI_F rises. At that edge every derived clock has just spent its final low phase, so a group stops after a complete cycle, parks low, and restarts with a full high phase. The CPU group restarts at the first PCI_F rising edge that sees the release. The PCI group waits one further full PCI_F period before it restarts.

A mode strap is loaded on every clock while reset is held. A strap of 0 honours the stop inputs. A strap of 1 keeps every group running and ignores the stop inputs. The board is expected to pull the strap high when nothing drives it.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_n is low, every clock output is 0. On the first reference edge after release, pcif_clk_o, every cpu_clk_o bit and every pci_clk_o bit go to 1, with both groups enabled.
- R2: Number the reference edges after reset release as n = 0, 1, 2, and so on. After edge n, pcif_clk_o is 1 when n mod 8 is 0 to 3, and 0 otherwise. An enabled CPU group is 1 when n is even and 0 when n is odd.
- R3: pcif_clk_o follows R2 on every edge, whatever the stop inputs do. A PCI_F rising edge is an edge with n mod 8 = 0.
- R4: Let d be the value of cpu_stop_n sampled at edge b−2, or 1 when b < 2. At each PCI_F rising edge b with the strap at 0, the CPU group is enabled when d = 1 and stopped when d = 0. A stopped group holds every cpu_clk_o bit at 0, and its enable never changes on any other edge.
- R5: A CPU group that is re-enabled at a PCI_F rising edge drives 1 on that same edge, so its first cycle is full.
- R6: A PCI_F rising edge b with the strap at 0 whose pci_stop_n sample at edge b−2 is 0 stops the PCI group. All pci_clk_o bits then stay 0, and the CPU group and pcif_clk_o are not affected.
- R7: A stopped PCI group restarts only at a PCI_F rising edge b where the pci_stop_n samples taken at edges b−2 and b−10 are both 1. This gives exactly one full PCI_F period of latency, and the group restarts with a high phase.
- R8: When mode_strap is 1 during reset, both groups run continuously until the next reset, whatever the stop inputs do.
- R9: No runt pulses occur. Each high phase of pci_clk_o lasts exactly 4 reference cycles and each low phase lasts at least 4. Each CPU high phase lasts exactly 1 cycle. A gated bit is high only while pcif_clk_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | Mode strap, loaded while reset is low; 0 honours the stop inputs |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the CPU group |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the PCI group |
| cpu_clk_o | output | NUM_CPU | CPU group clocks, reference/2 |
| pcif_clk_o | output | 1 | Free-running PCI_F clock, reference/8 |
| pci_clk_o | output | NUM_PCI | Gated PCI group clocks |

## Verification
The stop inputs are driven in several patterns: long holds, one-cycle pulses, changes placed just before and just after the sampling cutoff of a PCI_F boundary, and seeded random hold lengths. On every edge the bench compares all outputs with a model of the boundary rule that it computes from the history of the input samples. Pulses placed near the cutoff show whether the gating decision takes the sample from the correct edge. Short PCI releases show the difference between a restart after one period and an immediate restart. A second run with the strap at 1 sends the same kind of stimulus, and any gating at all is an error there. Counters of run length check separately that no output phase is cut short.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Level of a divided clock at a given phase: high for the first half of
  // each 2**div_log2 window.
  function automatic logic phase_level(input logic [7:0] ph, input int unsigned div_log2);
    return ~ph[div_log2-1];
  endfunction

  // True on the phase whose next edge starts a new slow-clock period.
  function automatic logic last_phase(input logic [7:0] ph, input int unsigned width);
    logic [7:0] mask;
    mask = 8'((9'd1 << width) - 9'd1);
    return (ph & mask) == mask;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
  parameter int unsigned PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_nxt,
  output logic            wrap
);
  import clkstop_pkg::*;
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '1;
    else        ph <= ph_nxt;
  end

  assign ph_nxt = ph + 1'b1;
  assign wrap   = last_phase(8'(ph), PH_W);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned RESTART_PERIODS = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic run_req,
  output logic en_q,
  output logic en_d
);
  localparam int unsigned CW = (RESTART_PERIODS > 0) ? $clog2(RESTART_PERIODS + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(RESTART_PERIODS);

  logic [CW-1:0] wait_q, wait_d;

  always_comb begin
    en_d   = en_q;
    wait_d = wait_q;
    if (wrap) begin
      if (!run_req) begin
        en_d   = 1'b0;
        wait_d = '0;
      end else if (!en_q) begin
        if (wait_q == LIMIT) en_d = 1'b1;
        else                 wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      wait_q <= LIMIT;
    end else begin
      en_q   <= en_d;
      wait_q <= wait_d;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_PCI = 5,
  parameter int unsigned CPU_DIV_LOG2 = 1,
  parameter int unsigned PCIF_DIV_LOG2 = 3,
  parameter int unsigned PCI_RESTART_PERIODS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_strap,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  output logic [NUM_CPU-1:0] cpu_clk_o,
  output logic               pcif_clk_o,
  output logic [NUM_PCI-1:0] pci_clk_o
);
  import clkstop_pkg::*;
  localparam int unsigned PH_W = PCIF_DIV_LOG2;

  logic [PH_W-1:0] ph_nxt;
  logic            wrap;
  logic [1:0]      stop_s;
  logic            mode_q;
  logic            cpu_run, pci_run;
  logic            cpu_en, cpu_en_d, pci_en, pci_en_d;
  logic            cpu_lvl, pcif_lvl;

  clkstop_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .wrap(wrap)
  );

  clkstop_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({pci_stop_n, cpu_stop_n}), .sync_o(stop_s)
  );

  // Strap is loaded on every clock while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap;
  end

  assign cpu_run = mode_q | stop_s[0];
  assign pci_run = mode_q | stop_s[1];

  clkstop_gate #(.RESTART_PERIODS(0)) u_cpu_gate (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .run_req(cpu_run),
    .en_q(cpu_en), .en_d(cpu_en_d)
  );

  clkstop_gate #(.RESTART_PERIODS(PCI_RESTART_PERIODS)) u_pci_gate (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .run_req(pci_run),
    .en_q(pci_en), .en_d(pci_en_d)
  );

  assign cpu_lvl  = phase_level(8'(ph_nxt), CPU_DIV_LOG2);
  assign pcif_lvl = phase_level(8'(ph_nxt), PCIF_DIV_LOG2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcif_clk_o <= 1'b0;
    else        pcif_clk_o <= pcif_lvl;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_clk_o[c] <= 1'b0;
      else        cpu_clk_o[c] <= cpu_lvl & cpu_en_d;
    end
  end

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pci_clk_o[p] <= 1'b0;
      else        pci_clk_o[p] <= pcif_lvl & pci_en_d;
    end
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_PCI = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrap,
  input logic               cpu_en,
  input logic               pci_en,
  input logic               mode_q,
  input logic [NUM_CPU-1:0] cpu_clk_o,
  input logic               pcif_clk_o,
  input logic [NUM_PCI-1:0] pci_clk_o
);
  AST_PCIF_RISE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> pcif_clk_o); // R2
  AST_PCIF_RISE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(pcif_clk_o) |-> $past(wrap)); // R3
  AST_CPU_EN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) (cpu_en != $past(cpu_en)) |-> $past(wrap)); // R4
  AST_CPU_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cpu_en |-> (cpu_clk_o == '0)); // R4
  AST_CPU_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_en) |-> (cpu_clk_o == '1)); // R5
  AST_PCI_EN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) (pci_en != $past(pci_en)) |-> $past(wrap)); // R6
  AST_PCI_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n) !pci_en |-> (pci_clk_o == '0)); // R6
  AST_PCI_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(pci_en) |-> ((pci_clk_o == '1) && pcif_clk_o)); // R7
  AST_STRAP_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n) mode_q |-> (cpu_en && pci_en)); // R8
  AST_PCI_INSIDE_PCIF: assert property (@(posedge clk) disable iff (!rst_n) (|pci_clk_o) |-> pcif_clk_o); // R9
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .cpu_en(cpu_en), .pci_en(pci_en),
  .mode_q(mode_q), .cpu_clk_o(cpu_clk_o), .pcif_clk_o(pcif_clk_o), .pci_clk_o(pci_clk_o)
);

// File: tb/sim_clkstop_ctrl.sv
module sim_clkstop_ctrl;
  localparam int NC = 2;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_strap = 1'b0;
  logic          cpu_stop_n = 1'b1;
  logic          pci_stop_n = 1'b1;
  logic [NC-1:0] cpu_clk_o;
  logic          pcif_clk_o;
  logic [NP-1:0] pci_clk_o;

  int  n_chk = 0, n_bad = 0;
  int  nedge = 0, cur = -1;
  bit  chist [0:8191];
  bit  phist [0:8191];
  bit  strap_cur = 1'b0;
  bit  ecen = 1'b1, epen = 1'b1, prev_ps = 1'b1;
  int  run_pcif_hi = 0, run_pci_hi = 0, run_pci_lo = 0, run_cpu_hi = 0;
  bit  last_pcif = 1'b0, last_pci = 1'b0, last_cpu = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  clkstop_ctrl #(.NUM_CPU(NC), .NUM_PCI(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_clk_o(cpu_clk_o), .pcif_clk_o(pcif_clk_o), .pci_clk_o(pci_clk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s edge=%0d actual=%0h expected=%0h", req, cur, act, exp_v);
    end
  endtask

  function automatic bit sample_at(input int idx, input bit is_pci);
    if (idx < 0) return 1'b1;
    return is_pci ? phist[idx] : chist[idx];
  endfunction

  // Record the input samples taken at each edge after reset release.
  always @(posedge clk) begin
    if (rst_n) begin
      cur = nedge;
      chist[cur] = cpu_stop_n;
      phist[cur] = pci_stop_n;
      nedge = nedge + 1;
    end
  end

  // Compare outputs away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cur >= 0 && !done) begin
      bit cs, ps, ecpu, epcif;
      int ph;
      ph = cur % 8;
      if (ph == 0) begin
        cs = sample_at(cur - 2, 1'b0);
        ps = sample_at(cur - 2, 1'b1);
        if (strap_cur) begin
          ecen = 1'b1; epen = 1'b1;
        end else begin
          ecen = cs;
          epen = ps && (epen || prev_ps);
        end
        prev_ps = ps;
      end
      epcif = (ph < 4);
      ecpu  = ((ph % 2) == 0) && ecen;
      if (cur == 0)
        check(pcif_clk_o && cpu_clk_o == '1 && pci_clk_o == '1, "R1",
              {pcif_clk_o, cpu_clk_o, pci_clk_o}, 8'hFF);
      check(pcif_clk_o == epcif, "R3", pcif_clk_o, epcif);
      check(cpu_clk_o == {NC{ecpu}}, strap_cur ? "R8" : (ecen ? "R5" : "R4"),
            cpu_clk_o, {NC{ecpu}});
      check(pci_clk_o == {NP{epcif && epen}}, strap_cur ? "R8" : (epen ? "R7" : "R6"),
            pci_clk_o, {NP{epcif && epen}});
      // R9: run-length checks on the observed waveforms
      if (cur > 0) begin
        if (last_pcif && !pcif_clk_o) check(run_pcif_hi == 4, "R9", run_pcif_hi, 4);
        if (last_cpu && !cpu_clk_o[0]) check(run_cpu_hi == 1, "R9", run_cpu_hi, 1);
        if (last_pci && !pci_clk_o[0]) check(run_pci_hi == 4, "R9", run_pci_hi, 4);
        if (!last_pci && pci_clk_o[0]) check(run_pci_lo >= 4, "R9", run_pci_lo, 4);
      end
      run_pcif_hi = (pcif_clk_o && (last_pcif || cur == 0)) ? run_pcif_hi + 1 : (pcif_clk_o ? 1 : 0);
      run_cpu_hi  = cpu_clk_o[0] ? (last_cpu ? run_cpu_hi + 1 : 1) : 0;
      run_pci_hi  = pci_clk_o[0] ? (last_pci ? run_pci_hi + 1 : 1) : 0;
      run_pci_lo  = pci_clk_o[0] ? 0 : (last_pci ? 1 : run_pci_lo + 1);
      last_pcif = pcif_clk_o; last_cpu = cpu_clk_o[0]; last_pci = pci_clk_o[0];
    end
  end

  task automatic wait_cyc(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 1'b0;
    mode_strap = strap;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    wait_cyc(4);
    check(cpu_clk_o == '0 && pcif_clk_o == 1'b0 && pci_clk_o == '0, "R1",
          {cpu_clk_o, pcif_clk_o, pci_clk_o}, 0);
    nedge = 0; cur = -1;
    strap_cur = strap;
    ecen = 1'b1; epen = 1'b1; prev_ps = 1'b1;
    run_pcif_hi = 0; run_pci_hi = 0; run_pci_lo = 8; run_cpu_hi = 0;
    last_pcif = 1'b0; last_pci = 1'b0; last_cpu = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic random_phase(input int cycles);
    int t = 0;
    while (t < cycles) begin
      int len;
      len = 1 + int'($urandom_range(0, 39));
      case ($urandom_range(0, 3))
        0: cpu_stop_n = ~cpu_stop_n;
        1: pci_stop_n = ~pci_stop_n;
        2: begin cpu_stop_n = ~cpu_stop_n; pci_stop_n = ~pci_stop_n; end
        default: ;
      endcase
      wait_cyc(len);
      t += len;
    end
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    wait_cyc(40);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    do_reset(1'b0);
    wait_cyc(20);
    // Directed: long CPU stop and release (R4, R5)
    cpu_stop_n = 1'b0; wait_cyc(30); cpu_stop_n = 1'b1; wait_cyc(30);
    // Directed: PCI stop and release, one-period restart latency (R6, R7)
    pci_stop_n = 1'b0; wait_cyc(30); pci_stop_n = 1'b1; wait_cyc(40);
    // Directed: one-cycle pulses at every offset within a PCI_F period
    for (int off = 0; off < 8; off++) begin
      wait_cyc(off + 1);
      cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
      wait_cyc(1);
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      wait_cyc(24);
    end
    // Directed: PCI release held for only one period, then stopped again (R7)
    pci_stop_n = 1'b0; wait_cyc(20); pci_stop_n = 1'b1; wait_cyc(8);
    pci_stop_n = 1'b0; wait_cyc(20); pci_stop_n = 1'b1; wait_cyc(40);
    random_phase(2500);
    // Strap at 1: stop inputs ignored (R8)
    do_reset(1'b1);
    wait_cyc(10);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; wait_cyc(40);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; wait_cyc(10);
    random_phase(800);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog edge=%0d actual=0 expected=1", cur);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule